// File: doc/BRIEF.md
# Local Interrupt Countdown Timer

This block is a per-core countdown timer that raises a local interrupt request. Its behaviour at expiry is set by a packed 32-bit vector-table word held in a register. Software programs that word and an initial-count register through a one-cycle write port. A separate read port returns the word, the initial count or the live current count.

The count steps down by one on each cycle in which the tick enable is high. When it passes from one to zero, the block emits a one-cycle request carrying the word's vector, delivery mode and trigger mode, unless the mask bit is set. The periodic bit decides, masked or not, whether the counter reloads from the initial count or stops at zero. Writing the initial count starts or restarts the countdown at once, and writing zero stops it.

Top module: `lvt_timer`

## Requirements
- R1: After reset the vector-table word reads 0x0001_0000 (only the mask set), the initial count and the current count read 0, and `irq_valid_o` is low.
- R2: A write with `wr_sel_i`=0 stores the word's writable fields: vector [7:0], delivery mode [10:8], polarity [13], trigger mode [15], mask [16] and periodic [17]. Delivery status [12], remote request [14], bit 11 and bits [31:18] always read 0.
- R3: A write with `wr_sel_i`=1 stores the initial count and loads the same value into the current count, visible in the cycle after the write edge, whether or not the timer was running.
- R4: The current count falls by one on each clock edge where `tick_i` is high and the count is above one. It is unchanged on edges without a tick.
- R5: A tick edge at count 1 is an expiry. With the mask clear, `irq_valid_o` is high for exactly the following cycle, with `irq_vector_o`, `irq_mode_o` and `irq_level_o` taken from bits [7:0], [10:8] and [15] of the word held before that edge.
- R6: At an expiry with the mask set, no request is issued, but the reload or stop decision of R7/R8 is still taken.
- R7: At an expiry with periodic set, the current count reloads from the initial-count register and the countdown continues.
- R8: At an expiry with periodic clear, the count stays at 0 and no further request is issued until the initial count is written again.
- R9: Writing an initial count of 0 stops the timer without any request, and later ticks produce none.
- R10: An initial-count write on the same edge as a tick at count 1 takes precedence: the count takes the written value and no request is issued.
- R11: `rd_data_o` returns the word for `rd_sel_i`=0, the initial count for 1, the current count for 2 and zero for 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Countdown enable, one step per high cycle |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 vector-table word, 1 initial count |
| wr_data_i | input | 32 | Write data |
| rd_sel_i | input | 2 | Read select: 0 word, 1 initial count, 2 current count, 3 zero |
| rd_data_o | output | 32 | Combinational read data |
| irq_valid_o | output | 1 | One-cycle interrupt request |
| irq_vector_o | output | 8 | Request vector |
| irq_mode_o | output | 3 | Request delivery mode |
| irq_level_o | output | 1 | Request trigger mode (1 = level) |

## Verification
Register writes, the count step and the request are all registered on the same edge. Each result is therefore due one cycle after its stimulus edge, and the read port shows the new state as soon as that edge has passed. The bench drives each cycle's inputs on the falling edge and updates its model in step with the rising edge. It samples 1 ns after that edge and compares request, fields and read data against the model. This holds in the directed corner sequences (expiry, reload, masked expiry, zero write, write colliding with expiry) and in a long seeded random run.

// File: rtl/lvt_timer_pkg.sv
package lvt_timer_pkg;

  typedef struct packed {
    logic [13:0] rsvd_hi;
    logic        periodic;
    logic        mask;
    logic        trigger;
    logic        remote_req;
    logic        polarity;
    logic        dlv_status;
    logic        rsvd_11;
    logic [2:0]  mode;
    logic [7:0]  vector;
  } lvt_word_t;

  localparam logic [31:0] LVT_WR_MASK = 32'h0003_A7FF;
  localparam logic [31:0] LVT_RST_VAL = 32'h0001_0000;

  typedef enum logic       {WSEL_LVT = 1'b0, WSEL_INIT = 1'b1} wsel_e;
  typedef enum logic [1:0] {RSEL_LVT = 2'd0, RSEL_INIT = 2'd1, RSEL_CUR = 2'd2, RSEL_NONE = 2'd3} rsel_e;

  typedef struct packed {
    logic       valid;
    logic [7:0] vector;
    logic [2:0] mode;
    logic       level;
  } irq_req_t;

endpackage

// File: rtl/lvt_timer_regs.sv
module lvt_timer_regs
  import lvt_timer_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  wsel_e            wr_sel_i,
  input  logic [31:0]      wr_data_i,
  output lvt_word_t        lvt_o,
  output logic [CNT_W-1:0] init_o,
  output logic             load_o,
  output logic [CNT_W-1:0] load_val_o
);

  logic lvt_we;

  assign lvt_we     = wr_en_i && (wr_sel_i == WSEL_LVT);
  assign load_o     = wr_en_i && (wr_sel_i == WSEL_INIT);
  assign load_val_o = wr_data_i[CNT_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvt_o  <= lvt_word_t'(LVT_RST_VAL);
      init_o <= '0;
    end else begin
      // status-type bits are not software writable
      if (lvt_we) lvt_o <= lvt_word_t'(wr_data_i & LVT_WR_MASK);
      if (load_o) init_o <= load_val_o;
    end
  end

endmodule

// File: rtl/lvt_timer_counter.sv
module lvt_timer_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic [CNT_W-1:0] reload_val_i,
  input  logic             periodic_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    // a load on the same edge wins over expiry
    expire_o = tick_i && !load_i && (cnt_o == ONE);
    cnt_d    = cnt_o;
    if (load_i)                        cnt_d = load_val_i;
    else if (expire_o)                 cnt_d = periodic_i ? reload_val_i : '0;
    else if (tick_i && cnt_o != '0)    cnt_d = cnt_o - ONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_o <= '0;
    else         cnt_o <= cnt_d;
  end

endmodule

// File: rtl/lvt_timer_req.sv
module lvt_timer_req
  import lvt_timer_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       expire_i,
  input  logic       mask_i,
  input  logic [7:0] vector_i,
  input  logic [2:0] mode_i,
  input  logic       trigger_i,
  output irq_req_t   req_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_o <= '0;
    end else begin
      req_o.valid <= expire_i && !mask_i;
      if (expire_i && !mask_i) begin
        req_o.vector <= vector_i;
        req_o.mode   <= mode_i;
        req_o.level  <= trigger_i;
      end
    end
  end

endmodule

// File: rtl/lvt_timer.sv
module lvt_timer
  import lvt_timer_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        tick_i,
  input  logic        wr_en_i,
  input  logic        wr_sel_i,
  input  logic [31:0] wr_data_i,
  input  logic [1:0]  rd_sel_i,
  output logic [31:0] rd_data_o,
  output logic        irq_valid_o,
  output logic [7:0]  irq_vector_o,
  output logic [2:0]  irq_mode_o,
  output logic        irq_level_o
);

  lvt_word_t        lvt_q;
  logic [CNT_W-1:0] init_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] load_val;
  logic             load;
  logic             expire;
  irq_req_t         req;

  lvt_timer_regs #(.CNT_W(CNT_W)) i_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_sel_i   (wsel_e'(wr_sel_i)),
    .wr_data_i  (wr_data_i),
    .lvt_o      (lvt_q),
    .init_o     (init_q),
    .load_o     (load),
    .load_val_o (load_val)
  );

  lvt_timer_counter #(.CNT_W(CNT_W)) i_counter (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tick_i       (tick_i),
    .load_i       (load),
    .load_val_i   (load_val),
    .reload_val_i (init_q),
    .periodic_i   (lvt_q.periodic),
    .cnt_o        (cnt_q),
    .expire_o     (expire)
  );

  lvt_timer_req i_req (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .expire_i  (expire),
    .mask_i    (lvt_q.mask),
    .vector_i  (lvt_q.vector),
    .mode_i    (lvt_q.mode),
    .trigger_i (lvt_q.trigger),
    .req_o     (req)
  );

  always_comb begin
    unique case (rsel_e'(rd_sel_i))
      RSEL_LVT:  rd_data_o = lvt_q;
      RSEL_INIT: rd_data_o = 32'(init_q);
      RSEL_CUR:  rd_data_o = 32'(cnt_q);
      default:   rd_data_o = '0;
    endcase
  end

  assign irq_valid_o  = req.valid;
  assign irq_vector_o = req.vector;
  assign irq_mode_o   = req.mode;
  assign irq_level_o  = req.level;

endmodule

// File: rtl/lvt_timer_chk.sv
module lvt_timer_chk #(
  parameter int unsigned CNT_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic             load,
  input logic [CNT_W-1:0] load_val,
  input logic [CNT_W-1:0] init_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic [31:0]      lvt_q,
  input logic             expire,
  input logic             irq_valid_o,
  input logic [7:0]       irq_vector_o
);

  AST_LOAD_CNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(load) |-> cnt_q == $past(load_val)); // R3

  AST_STEP_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(tick_i && !load && cnt_q > CNT_W'(1)) |-> cnt_q == $past(cnt_q) - CNT_W'(1)); // R4

  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!tick_i && !load) |-> cnt_q == $past(cnt_q)); // R4

  AST_REQ_FIELDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_valid_o |-> irq_vector_o == $past(lvt_q[7:0])); // R5

  AST_MASK_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(lvt_q[16]) |-> !irq_valid_o); // R6

  AST_PERIODIC_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(expire && lvt_q[17]) |-> cnt_q == $past(init_q)); // R7

  AST_ONESHOT_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(expire && !lvt_q[17]) |-> cnt_q == '0); // R8

  AST_REQ_NEEDS_EXPIRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_valid_o |-> $past(tick_i && !load && cnt_q == CNT_W'(1))); // R10

endmodule

bind lvt_timer lvt_timer_chk #(.CNT_W(CNT_W)) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .tick_i       (tick_i),
  .load         (load),
  .load_val     (load_val),
  .init_q       (init_q),
  .cnt_q        (cnt_q),
  .lvt_q        (lvt_q),
  .expire       (expire),
  .irq_valid_o  (irq_valid_o),
  .irq_vector_o (irq_vector_o)
);

// File: tb/test_lvt_timer.sv
`timescale 1ns/1ps
module test_lvt_timer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_sel = 1'b0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_sel = '0;
  logic [31:0] rd_data;
  logic        irq_valid;
  logic [7:0]  irq_vector;
  logic [2:0]  irq_mode;
  logic        irq_level;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [31:0] m_lvt  = 32'h0001_0000;
  logic [31:0] m_init = '0;
  logic [31:0] m_cnt  = '0;
  int          req_seen = 0;

  always #2 clk = ~clk;

  lvt_timer i_lvt_timer (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .rd_sel_i(rd_sel), .rd_data_o(rd_data),
    .irq_valid_o(irq_valid), .irq_vector_o(irq_vector), .irq_mode_o(irq_mode),
    .irq_level_o(irq_level)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(input logic [1:0] rs);
    case (rs)
      2'd0:    return m_lvt;
      2'd1:    return m_init;
      2'd2:    return m_cnt;
      default: return 32'h0;
    endcase
  endfunction

  // one cycle: drive at negedge, model the edge, sample 1 ns after it
  task automatic step(input bit tk, input bit we, input bit ws, input logic [31:0] wd,
                      input logic [1:0] rs, input string tag);
    bit          load, lwr, expv, e_valid;
    logic [31:0] e_req;
    @(negedge clk);
    tick = tk; wr_en = we; wr_sel = ws; wr_data = wd; rd_sel = rs;
    load    = we && ws;
    lwr     = we && !ws;
    expv    = tk && !load && (m_cnt == 32'd1);
    e_valid = expv && !m_lvt[16];
    e_req   = {20'h0, m_lvt[15], m_lvt[10:8], m_lvt[7:0]};
    @(posedge clk);
    #1;
    if (load)               m_cnt = wd;
    else if (expv)          m_cnt = m_lvt[17] ? m_init : 32'h0;
    else if (tk && m_cnt != 0) m_cnt = m_cnt - 1;
    if (load) m_init = wd;
    if (lwr)  m_lvt  = wd & 32'h0003_A7FF;
    chk(irq_valid == e_valid, {tag, " valid"}, {31'h0, irq_valid}, {31'h0, e_valid});
    if (e_valid) begin
      req_seen++;
      chk({20'h0, irq_level, irq_mode, irq_vector} == e_req, {tag, " fields R5"},
          {20'h0, irq_level, irq_mode, irq_vector}, e_req);
    end
    chk(rd_data == exp_read(rs), {tag, " read R11"}, rd_data, exp_read(rs));
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    step(0, 0, 0, 0, 2'd0, "R1 lvt");
    step(0, 0, 0, 0, 2'd1, "R1 init");
    step(0, 0, 0, 0, 2'd2, "R1 cur");
    step(1, 0, 0, 0, 2'd3, "R1 idle tick");

    // R2 writable fields only
    step(0, 1, 0, 32'hFFFF_FFFF, 2'd0, "R2 all ones");
    chk(rd_data == 32'h0003_A7FF, "R2 mask", rd_data, 32'h0003_A7FF);
    step(0, 1, 0, 32'h0000_5000, 2'd0, "R2 status bits");
    chk(rd_data == 32'h0, "R2 ro", rd_data, 32'h0);

    // R5 R8 one-shot unmasked
    step(0, 1, 0, 32'h0000_8342, 2'd0, "R5 setup");
    step(0, 1, 1, 32'd3, 2'd2, "R3 load");
    chk(rd_data == 32'd3, "R3 cur", rd_data, 32'd3);
    step(1, 0, 0, 0, 2'd2, "R4 tick");
    step(0, 0, 0, 0, 2'd2, "R4 hold");
    step(1, 0, 0, 0, 2'd2, "R4 tick");
    step(1, 0, 0, 0, 2'd2, "R5 expiry");
    chk(irq_valid === 1'b1 && irq_vector == 8'h42, "R5 pulse", {31'h0, irq_valid}, 32'h1);
    step(0, 0, 0, 0, 2'd2, "R5 single");
    for (int i = 0; i < 5; i++) step(1, 0, 0, 0, 2'd2, "R8 stopped");

    // R7 periodic
    step(0, 1, 0, 32'h0002_0021, 2'd0, "R7 setup");
    step(0, 1, 1, 32'd2, 2'd1, "R7 load");
    for (int i = 0; i < 8; i++) step(1, 0, 0, 0, 2'd2, "R7 periodic");
    // R3 restart while running
    step(0, 1, 1, 32'd5, 2'd2, "R3 restart");

    // R6 masked periodic
    step(0, 1, 0, 32'h0003_0021, 2'd0, "R6 setup");
    for (int i = 0; i < 12; i++) step(1, 0, 0, 0, 2'd2, "R6 masked");

    // R9 zero write
    step(0, 1, 0, 32'h0002_0055, 2'd0, "R9 setup");
    step(1, 0, 0, 0, 2'd2, "R9 run");
    step(0, 1, 1, 32'd0, 2'd2, "R9 zero");
    for (int i = 0; i < 4; i++) step(1, 0, 0, 0, 2'd2, "R9 quiet");

    // R10 load collides with expiry
    step(0, 1, 1, 32'd1, 2'd2, "R10 arm");
    step(1, 1, 1, 32'd7, 2'd2, "R10 collide");
    chk(irq_valid == 1'b0 && rd_data == 32'd7, "R10 result", rd_data, 32'd7);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      bit          tk, we, ws;
      logic [31:0] wd;
      tk = ($urandom % 4) != 0;
      we = ($urandom % 12) == 0;
      ws = $urandom % 2;
      wd = ws ? ($urandom % 9) : $urandom;
      step(tk, we, ws, wd, 2'($urandom % 4), "rnd R4 R5 R6 R7 R8");
    end
    chk(req_seen > 10, "R5 coverage", req_seen, 32'd11);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule